// File: doc/BRIEF.md
# Pulse-Swallowing Feedback Divider

This block divides a fast input clock by a programmable integer N and emits one single-cycle pulse per division cycle. It is the feedback divider of a frequency synthesizer loop. A short prescaler alternates between two moduli. A swallow counter decides how many prescaler periods use the longer modulus. A main counter counts prescaler periods until the cycle is over. Because the fast logic is confined to the small prescaler, the two programmable counters only advance once per prescaler period.

The settings are a 6-bit main count `M`, a 4-bit swallow count `A` and a doubling bit. With the doubling bit low, the prescaler divides by 6 or 7. With it high, the prescaler divides by 12 or 14. For valid settings (`A <= M`) the cycle length is `(M+1)*6 + A`, and `7*(M+1)` when `A` is zero, doubled when the doubling bit is set.

Settings are captured at each cycle boundary, so they can be changed at any time without breaking the cycle in progress. A synchronous jam input holds every counter at its reload point. An illegal-setting flag reports `A > M`, and the divider keeps running with the values as given.

Top module: `fbdiv_top`

## Requirements
- R1: During reset `fb_pulse` is 0. The first clock edge after reset is released loads the settings, and the first pulse appears N edges after that load edge.
- R2: With the doubling bit 0 and 1 <= A <= M, consecutive pulses are exactly (M+1)*6 + A clock cycles apart (for example M=5, A=1 gives 37; M=63, A=15 gives 399).
- R3: With A = 0, every prescaler period uses the longer modulus and the cycle is 7*(M+1) clocks (M=0 gives 7; M=63 gives 448).
- R4: With the doubling bit 1, the prescaler moduli become 12 and 14 and every cycle length is twice the R2/R3 value (M=63, A=0 gives 896).
- R5: `fb_pulse` is high for exactly one clock per division cycle, in the cycle after the last input clock of that division cycle, and repeats with a period of N.
- R6: While `jam` is high, no pulse is produced and all counters sit at their reload point. The first pulse appears N edges after the last edge on which `jam` was high.
- R7: M, A and the doubling bit are sampled only at a load edge (reset release, jam, or end of cycle). A change in the middle of a cycle does not alter that cycle's length and applies from the next cycle.
- R8: `bad_cfg` is 1 exactly when A > M, combinationally from the inputs. In that case the divider still runs, using min(A, M+1) long periods: N = (M+1)*6 + min(A, M+1) (M=2, A=5 gives 21).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Asynchronous active-low reset |
| jam | input | 1 | Synchronous hold of all counters at reload |
| m_val | input | 6 | Main counter setting; prescaler periods per cycle minus one |
| a_val | input | 4 | Swallow count; number of long prescaler periods |
| dbl | input | 1 | 1 selects the 12/14 prescaler |
| fb_pulse | output | 1 | One-clock pulse per completed division cycle |
| bad_cfg | output | 1 | High when a_val exceeds m_val |

## Verification
A fault in the swallow counter or in the prescaler modulus select changes the pulse spacing by one or more clocks. It shows in the first full interval after a load, so the bench measures both the jam-to-pulse distance and the following pulse-to-pulse interval for every setting. A main counter that reloads wrongly is off by a multiple of 6, 7, 12 or 14 in that same first interval. A capture fault at the cycle boundary only shows in the cycle after a mid-cycle settings change, which is why that interval is measured on its own.

// File: rtl/fbdiv_pkg.sv
package fbdiv_pkg;

  // short modulus of the prescaler; the long one is PRE_BASE + 1
  localparam int unsigned PRE_BASE = 6;

  // length of one prescaler period in input clocks
  function automatic int unsigned presc_len(input logic use_long, input logic dbl);
    int unsigned len;
    len = use_long ? PRE_BASE + 1 : PRE_BASE;
    return dbl ? (len * 2) : len;
  endfunction

  // total division cycle length for settings taken as-is
  function automatic int unsigned fold_modulus(input int unsigned m, input int unsigned a,
                                               input logic dbl);
    int unsigned periods;
    int unsigned longs;
    int unsigned total;
    periods = m + 1;
    if (a == 0) longs = periods;
    else if (a > periods) longs = periods;
    else longs = a;
    total = periods * PRE_BASE + longs;
    return dbl ? (total * 2) : total;
  endfunction

endpackage

// File: rtl/fbdiv_presc.sv
module fbdiv_presc #(
  parameter int unsigned BASE = fbdiv_pkg::PRE_BASE,
  localparam int unsigned CW = $clog2(2 * (BASE + 1))
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic use_long,
  input  logic dbl,
  output logic tc
);
  logic [CW-1:0] pcnt;
  logic [CW-1:0] last_idx;

  always_comb begin
    last_idx = CW'(fbdiv_pkg::presc_len(use_long, dbl) - 1);
    tc = (pcnt == last_idx);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pcnt <= '0;
    else if (load || tc) pcnt <= '0;
    else pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/fbdiv_swallow.sv
module fbdiv_swallow #(
  parameter int unsigned A_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [A_W-1:0] a_set,
  input  logic           step,
  output logic           use_long
);
  logic [A_W-1:0] acnt;
  logic           all_long_q;

  assign use_long = all_long_q || (acnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acnt       <= '0;
      all_long_q <= 1'b1;
    end else if (load) begin
      acnt       <= a_set;
      all_long_q <= (a_set == '0);
    end else if (step && acnt != '0) begin
      acnt <= acnt - 1'b1;
    end
  end
endmodule

// File: rtl/fbdiv_mcnt.sv
module fbdiv_mcnt #(
  parameter int unsigned M_W = 6
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [M_W-1:0] m_set,
  input  logic           step,
  output logic           last
);
  logic [M_W-1:0] mcnt;

  assign last = (mcnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mcnt <= '0;
    else if (load) mcnt <= m_set;
    else if (step) mcnt <= mcnt - 1'b1;
  end
endmodule

// File: rtl/fbdiv_top.sv
module fbdiv_top #(
  parameter int unsigned M_W = 6,
  parameter int unsigned A_W = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           jam,
  input  logic [M_W-1:0] m_val,
  input  logic [A_W-1:0] a_val,
  input  logic           dbl,
  output logic           fb_pulse,
  output logic           bad_cfg
);
  logic start_q;
  logic dbl_q;
  logic pulse_q;
  logic presc_tc;
  logic use_long;
  logic m_last;
  logic cyc_end;
  logic cyc_load;

  assign cyc_end  = presc_tc && m_last;
  assign cyc_load = start_q || jam || cyc_end;

  fbdiv_presc #(.BASE(fbdiv_pkg::PRE_BASE)) u_presc (
    .clk(clk), .rst_n(rst_n), .load(cyc_load),
    .use_long(use_long), .dbl(dbl_q), .tc(presc_tc)
  );

  fbdiv_swallow #(.A_W(A_W)) u_swallow (
    .clk(clk), .rst_n(rst_n), .load(cyc_load),
    .a_set(a_val), .step(presc_tc), .use_long(use_long)
  );

  fbdiv_mcnt #(.M_W(M_W)) u_mcnt (
    .clk(clk), .rst_n(rst_n), .load(cyc_load),
    .m_set(m_val), .step(presc_tc), .last(m_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= 1'b1;
      dbl_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      pulse_q <= cyc_end && !jam && !start_q;
      if (cyc_load) dbl_q <= dbl;
    end
  end

  assign fb_pulse = pulse_q;
  assign bad_cfg  = (32'(a_val) > 32'(m_val));
endmodule

// File: rtl/fbdiv_chk.sv
module fbdiv_chk #(
  parameter int unsigned M_W = 6,
  parameter int unsigned A_W = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic           jam,
  input logic [M_W-1:0] m_val,
  input logic [A_W-1:0] a_val,
  input logic           dbl,
  input logic           fb_pulse,
  input logic           cyc_load,
  input logic           cyc_end
);
  logic [15:0] gap;
  logic [15:0] exp_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap   <= '0;
      exp_n <= 16'd1;
    end else if (cyc_load) begin
      gap   <= '0;
      exp_n <= 16'(fbdiv_pkg::fold_modulus(32'(m_val), 32'(a_val), dbl));
    end else if (gap != 16'hFFFF) begin
      gap <= gap + 1'b1;
    end
  end

  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fb_pulse |=> !fb_pulse);

  // R6
  jam_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    jam |=> !fb_pulse);

  // R5
  pulse_after_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_load |=> !fb_pulse);

  // R2 R3 R4 R8
  modulus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_end && !jam) |-> (gap == exp_n - 16'd1));
endmodule

bind fbdiv_top fbdiv_chk #(.M_W(M_W), .A_W(A_W)) u_fbdiv_chk (
  .clk(clk), .rst_n(rst_n), .jam(jam), .m_val(m_val), .a_val(a_val),
  .dbl(dbl), .fb_pulse(fb_pulse), .cyc_load(cyc_load), .cyc_end(cyc_end)
);

// File: tb/fbdiv_top_bench.sv
module fbdiv_top_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       jam = 1'b0;
  logic [5:0] m_val = 6'd5;
  logic [3:0] a_val = 4'd1;
  logic       dbl = 1'b0;
  logic       fb_pulse;
  logic       bad_cfg;

  int n_checks = 0;
  int n_fails = 0;
  bit finished = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  fbdiv_top u_fbdiv_top (
    .clk(clk), .rst_n(rst_n), .jam(jam), .m_val(m_val), .a_val(a_val),
    .dbl(dbl), .fb_pulse(fb_pulse), .bad_cfg(bad_cfg)
  );

  // {m, a, dbl, expected N, requirement number}
  localparam logic [26:0] VECS [10] = '{
    {6'd5,  4'd1,  1'b0, 12'd37,  4'd2},  // R2
    {6'd10, 4'd3,  1'b0, 12'd69,  4'd2},  // R2
    {6'd63, 4'd15, 1'b0, 12'd399, 4'd2},  // R2
    {6'd7,  4'd0,  1'b0, 12'd56,  4'd3},  // R3
    {6'd63, 4'd0,  1'b0, 12'd448, 4'd3},  // R3
    {6'd0,  4'd0,  1'b0, 12'd7,   4'd3},  // R3
    {6'd5,  4'd1,  1'b1, 12'd74,  4'd4},  // R4
    {6'd20, 4'd9,  1'b1, 12'd270, 4'd4},  // R4
    {6'd63, 4'd0,  1'b1, 12'd896, 4'd4},  // R4
    {6'd2,  4'd5,  1'b0, 12'd21,  4'd8}   // R8
  };

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_pulse(output int k);
    k = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      k++;
    end while (!fb_pulse && k < 2000);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
    end
  end

  initial begin
    int k;
    // R1: reset state and first pulse
    repeat (3) @(negedge clk);
    check("R1 pulse in reset", int'(fb_pulse), 0);
    rst_n = 1'b1;
    wait_pulse(k);
    check("R1 first pulse distance", k, 38);
    wait_pulse(k);
    check("R5 period", k, 37);

    for (int i = 0; i < 10; i++) begin
      logic [26:0] v;
      string tag;
      v = VECS[i];
      tag = $sformatf("R%0d", v[3:0]);
      @(negedge clk);
      m_val = v[26:21];
      a_val = v[20:17];
      dbl   = v[16];
      jam   = 1'b1;
      #1;
      // R8: flag computed from inputs
      check({"R8 bad_cfg ", tag}, int'(bad_cfg), int'(v[20:17] > {2'b00, v[26:21]} ? 1 : 0));
      @(posedge clk);
      @(negedge clk);
      jam = 1'b0;
      // R6: distance from jam release
      wait_pulse(k);
      check({"R6 jam-to-pulse ", tag}, k, int'(v[15:4]));
      @(posedge clk);
      @(negedge clk);
      // R5: single cycle width
      check({"R5 width ", tag}, int'(fb_pulse), 0);
      wait_pulse(k);
      check({"period ", tag}, k + 1, int'(v[15:4]));
    end

    // R7: mid-cycle change applies from the next cycle
    @(negedge clk);
    m_val = 6'd5; a_val = 4'd1; dbl = 1'b0; jam = 1'b1;
    @(posedge clk);
    @(negedge clk);
    jam = 1'b0;
    wait_pulse(k);
    repeat (10) begin
      @(posedge clk);
      @(negedge clk);
    end
    m_val = 6'd7; a_val = 4'd0;
    wait_pulse(k);
    check("R7 current cycle kept", k, 27);
    wait_pulse(k);
    check("R7 new cycle", k, 56);

    // R6: held jam gives no pulse
    begin
      int seen;
      seen = 0;
      @(negedge clk);
      m_val = 6'd0; a_val = 4'd0; jam = 1'b1;
      repeat (50) begin
        @(posedge clk);
        @(negedge clk);
        if (fb_pulse) seen++;
      end
      check("R6 pulses under jam", seen, 0);
      jam = 1'b0;
      wait_pulse(k);
      check("R6 after long jam", k, 7);
    end

    finished = 1;
    summary();
  end
endmodule